// File: doc/BRIEF.md
# Sector Lock Unlock Sequencer

This block sits beside a 128K-byte memory array and watches every bus access made to it. Each access arrives as a one-cycle strobe carrying a 17-bit address, a data byte, a read/write flag and a flag telling whether the access opened a fresh chip select. The block holds an 8-bit lock mask. Each mask bit guards one 16K-byte sector, and a write into a locked sector is cancelled in the same cycle through a write-inhibit output.

The mask can change only after an exact unlock pattern. Software first issues six reads at 05555h, 1AAAAh, 03333h, 1CCCCh, 100FFh and 0FF00h, in that order. These reads go to the array as normal reads. The next access must be a write, and its byte becomes the pending mask. The access after that must be a write of the bitwise complement of the pending byte. When the complement is correct, the mask takes the pending value. A trailing write to 0FF00h may follow, and it is also kept from the array. Any deviation from the pattern silently restarts detection. The two mask-carrying writes never reach the array.

The lock mask is held in a plain register that has a reset default. This register models storage that would be nonvolatile in a real part.

Top module: `sector_lock_seq`

## Requirements
- R1: After reset, prot_mask is 00h (every sector writable), and no write is inhibited when no unlock pattern is in progress.
- R2: A valid write whose sector index addr[16:14] selects a prot_mask bit that is 1 asserts wr_inhibit in the same cycle as the strobe. A write to a sector whose bit is 0 is not inhibited unless the write is swallowed. A read never asserts wr_inhibit.
- R3: The following pattern loads the pending byte into prot_mask, and the new value is visible in the cycle after the complement write:
  - six reads at 05555h, 1AAAAh, 03333h, 1CCCCh, 100FFh and 0FF00h, in that order;
  - a write of any byte P;
  - a write of ~P.
- R4: The pending-byte write and the complement write are swallowed whatever their addresses are. Swallowed means that seq_swallow and wr_inhibit are both high in that write's cycle.
- R5: A read at an address other than the next expected one restarts detection. The next write after that is handled as a normal write, and prot_mask is unchanged.
- R6: A seventh read, arriving where the pending-byte write is expected, restarts detection.
- R7: If the write after the pending byte is not its exact complement, or if a read arrives in its place, prot_mask keeps its previous value and detection restarts. A mismatched write of this kind is still swallowed.
- R8: Directly after a successful update, a write to 0FF00h is swallowed. Any access after that is normal.
- R9: A read of 05555h starts the pattern only if acc_fresh is 1 or the immediately preceding valid access was a read of 00000h. Otherwise the read is ignored as a first step.
- R10: An access that breaks the pattern is itself evaluated as a possible first step. So a qualifying read of 05555h that breaks the pattern starts a new pattern at step one.
- R11: Cycles with acc_valid low do not advance or reset the pattern, do not change prot_mask, and assert neither wr_inhibit nor seq_swallow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | One-cycle strobe marking a bus access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_fresh | input | 1 | Access began with a new chip-select assertion |
| acc_addr | input | 17 | Byte address of the access |
| acc_data | input | 8 | Write data byte |
| prot_mask | output | 8 | Sector lock mask, bit n guards addresses n*4000h to n*4000h+3FFFh |
| wr_inhibit | output | 1 | Cancel the current write at the array |
| seq_swallow | output | 1 | Current write belongs to the unlock pattern |

## Verification
The hardest condition to reach is a changed prot_mask. Random accesses almost never complete six exact reads followed by a matching complement. The random stimulus therefore draws most addresses from the unlock list and the tail address. Whenever the bench's own model is waiting for the complement, the stimulus writes the correct complement about half the time. This drives the block through successful updates, aborted attempts and R10 restarts. Directed sequences cover each abort point separately, the stale-select case of R9 and idle gaps between pattern steps.

// File: rtl/sls_pkg.sv
package sls_pkg;

  localparam int ADDR_BITS  = 17;
  localparam int UNLOCK_LEN = 6;
  localparam int HIT_W      = $clog2(UNLOCK_LEN);

  localparam logic [ADDR_BITS-1:0] ZERO_ADDR = 17'h00000;
  localparam logic [ADDR_BITS-1:0] TAIL_ADDR = 17'h0FF00;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_PROT = 2'd1,
    PH_CPL  = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;

  // Address expected at a given position of the unlock read pattern.
  function automatic logic [ADDR_BITS-1:0] unlock_addr(input logic [HIT_W-1:0] idx);
    logic [ADDR_BITS-1:0] a;
    case (idx)
      3'd0:    a = 17'h05555;
      3'd1:    a = 17'h1AAAA;
      3'd2:    a = 17'h03333;
      3'd3:    a = 17'h1CCCC;
      3'd4:    a = 17'h100FF;
      3'd5:    a = 17'h0FF00;
      default: a = 17'h00000;
    endcase
    return a;
  endfunction

  // Check that one byte is the bitwise complement of another.
  function automatic logic is_complement(input logic [7:0] a, input logic [7:0] b);
    return (a ^ b) == 8'hFF;
  endfunction

endpackage

// File: rtl/sls_match.sv
module sls_match
  import sls_pkg::*;
(
  input  logic                 acc_write,
  input  logic                 acc_fresh,
  input  logic [ADDR_BITS-1:0] acc_addr,
  input  logic [HIT_W-1:0]     hits,
  input  logic                 zero_seen,
  output logic                 step_hit,
  output logic                 start_hit,
  output logic                 zero_rd,
  output logic                 tail_wr
);

  logic is_read;

  assign is_read   = !acc_write;
  assign step_hit  = is_read && (acc_addr == unlock_addr(hits));
  assign start_hit = is_read && (acc_addr == unlock_addr('0)) && (acc_fresh || zero_seen);
  assign zero_rd   = is_read && (acc_addr == ZERO_ADDR);
  assign tail_wr   = acc_write && (acc_addr == TAIL_ADDR);

endmodule

// File: rtl/sls_fsm.sv
module sls_fsm
  import sls_pkg::*;
#(
  parameter int          SECTORS    = 8,
  parameter logic [SECTORS-1:0] PROT_RESET = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [SECTORS-1:0] acc_data,
  input  logic               step_hit,
  input  logic               start_hit,
  input  logic               zero_rd,
  input  logic               tail_wr,
  output logic [HIT_W-1:0]   hits_q,
  output logic               zero_q,
  output logic [SECTORS-1:0] prot_q,
  output logic [SECTORS-1:0] pend_q,
  output logic               swallow,
  output logic               cpl_ok,
  output logic               seq_abort
);

  localparam logic [HIT_W-1:0] LAST_HIT = HIT_W'(UNLOCK_LEN - 1);
  localparam logic [HIT_W-1:0] ONE_HIT  = HIT_W'(1);

  phase_e             ph_q, ph_d;
  logic [HIT_W-1:0]   hits_d;
  logic [SECTORS-1:0] prot_d, pend_d;
  logic               cpl_match;

  assign cpl_match = ((acc_data ^ pend_q) == {SECTORS{1'b1}});

  always_comb begin
    ph_d      = ph_q;
    hits_d    = hits_q;
    prot_d    = prot_q;
    pend_d    = pend_q;
    swallow   = 1'b0;
    cpl_ok    = 1'b0;
    seq_abort = 1'b0;
    if (acc_valid) begin
      case (ph_q)
        PH_HUNT: begin
          if (hits_q != '0 && step_hit) begin
            if (hits_q == LAST_HIT) begin
              ph_d   = PH_PROT;
              hits_d = '0;
            end else begin
              hits_d = hits_q + ONE_HIT;
            end
          end else begin
            seq_abort = (hits_q != '0);
            hits_d    = start_hit ? ONE_HIT : '0;
          end
        end
        PH_PROT: begin
          if (acc_write) begin
            swallow = 1'b1;
            pend_d  = acc_data;
            ph_d    = PH_CPL;
          end else begin
            seq_abort = 1'b1;
            ph_d      = PH_HUNT;
            hits_d    = start_hit ? ONE_HIT : '0;
          end
        end
        PH_CPL: begin
          if (acc_write) begin
            swallow = 1'b1;
            hits_d  = '0;
            if (cpl_match) begin
              cpl_ok = 1'b1;
              prot_d = pend_q;
              ph_d   = PH_TAIL;
            end else begin
              seq_abort = 1'b1;
              ph_d      = PH_HUNT;
            end
          end else begin
            seq_abort = 1'b1;
            ph_d      = PH_HUNT;
            hits_d    = start_hit ? ONE_HIT : '0;
          end
        end
        PH_TAIL: begin
          swallow = tail_wr;
          ph_d    = PH_HUNT;
          hits_d  = start_hit ? ONE_HIT : '0;
        end
        default: begin
          ph_d   = PH_HUNT;
          hits_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HUNT;
      hits_q <= '0;
      zero_q <= 1'b0;
      prot_q <= PROT_RESET;
      pend_q <= '0;
    end else begin
      ph_q   <= ph_d;
      hits_q <= hits_d;
      prot_q <= prot_d;
      pend_q <= pend_d;
      if (acc_valid) zero_q <= zero_rd;
    end
  end

endmodule

// File: rtl/sls_guard.sv
module sls_guard
  import sls_pkg::*;
#(
  parameter int SECTORS = 8
) (
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [ADDR_BITS-1:0] acc_addr,
  input  logic [SECTORS-1:0]   prot,
  input  logic                 swallow,
  output logic                 blocked,
  output logic                 wr_inhibit
);

  localparam int IDX_W     = $clog2(SECTORS);
  localparam int SEC_SHIFT = ADDR_BITS - IDX_W;

  logic [SECTORS-1:0] sec_blk;

  for (genvar i = 0; i < SECTORS; i++) begin : g_sec
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    assign sec_blk[i] = prot[i] && (acc_addr[ADDR_BITS-1:SEC_SHIFT] == IDX);
  end

  assign blocked    = |sec_blk;
  assign wr_inhibit = acc_valid && acc_write && (blocked || swallow);

endmodule

// File: rtl/sector_lock_seq.sv
module sector_lock_seq
  import sls_pkg::*;
#(
  parameter int                 SECTORS    = 8,
  parameter logic [SECTORS-1:0] PROT_RESET = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic                 acc_fresh,
  input  logic [ADDR_BITS-1:0] acc_addr,
  input  logic [SECTORS-1:0]   acc_data,
  output logic [SECTORS-1:0]   prot_mask,
  output logic                 wr_inhibit,
  output logic                 seq_swallow
);

  logic [HIT_W-1:0]   hits_q;
  logic               zero_q;
  logic               step_hit, start_hit, zero_rd, tail_wr;
  logic               swallow, cpl_ok, seq_abort, blocked;
  logic [SECTORS-1:0] prot_q, pend_q;

  sls_match u_match (
    .acc_write (acc_write),
    .acc_fresh (acc_fresh),
    .acc_addr  (acc_addr),
    .hits      (hits_q),
    .zero_seen (zero_q),
    .step_hit  (step_hit),
    .start_hit (start_hit),
    .zero_rd   (zero_rd),
    .tail_wr   (tail_wr)
  );

  sls_fsm #(.SECTORS(SECTORS), .PROT_RESET(PROT_RESET)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_data  (acc_data),
    .step_hit  (step_hit),
    .start_hit (start_hit),
    .zero_rd   (zero_rd),
    .tail_wr   (tail_wr),
    .hits_q    (hits_q),
    .zero_q    (zero_q),
    .prot_q    (prot_q),
    .pend_q    (pend_q),
    .swallow   (swallow),
    .cpl_ok    (cpl_ok),
    .seq_abort (seq_abort)
  );

  sls_guard #(.SECTORS(SECTORS)) u_guard (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .prot       (prot_q),
    .swallow    (swallow),
    .blocked    (blocked),
    .wr_inhibit (wr_inhibit)
  );

  assign prot_mask   = prot_q;
  assign seq_swallow = swallow && acc_valid;

endmodule

// File: rtl/sls_chk.sv
module sls_chk
  import sls_pkg::*;
#(
  parameter int SECTORS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [ADDR_BITS-1:0] acc_addr,
  input logic [SECTORS-1:0]   acc_data,
  input logic [SECTORS-1:0]   prot_mask,
  input logic                 wr_inhibit,
  input logic                 seq_swallow,
  input logic                 cpl_ok,
  input logic                 seq_abort,
  input logic [SECTORS-1:0]   pend_q
);

  localparam int IDX_W = $clog2(SECTORS);

  // R2
  locked_write_inhibited_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && prot_mask[acc_addr[ADDR_BITS-1 -: IDX_W]]) |-> wr_inhibit);

  // R2
  inhibit_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |-> (acc_valid && acc_write));

  // R4
  swallow_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_swallow |-> wr_inhibit);

  // R3
  mask_change_needs_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_mask) |-> ($past(acc_valid && acc_write) && (($past(acc_data) ^ prot_mask) == {SECTORS{1'b1}})));

  // R3
  update_loads_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ok |=> (prot_mask == $past(pend_q)));

  // R7
  abort_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> $stable(prot_mask));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!wr_inhibit && !seq_swallow && !cpl_ok && !seq_abort));

endmodule

bind sector_lock_seq sls_chk #(.SECTORS(SECTORS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .acc_write   (acc_write),
  .acc_addr    (acc_addr),
  .acc_data    (acc_data),
  .prot_mask   (prot_mask),
  .wr_inhibit  (wr_inhibit),
  .seq_swallow (seq_swallow),
  .cpl_ok      (cpl_ok),
  .seq_abort   (seq_abort),
  .pend_q      (pend_q)
);

// File: tb/tb_sector_lock_seq.sv
module tb_sector_lock_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_fresh = 1'b0;
  logic [16:0] acc_addr = '0;
  logic [7:0]  acc_data = '0;
  logic [7:0]  prot_mask;
  logic        wr_inhibit, seq_swallow;

  int errors = 0;
  int checks = 0;

  // Bench-side view of the pattern: 0 hunting, 1 wants byte, 2 wants complement, 3 tail.
  int        m_ph = 0;
  int        m_hits = 0;
  bit        m_zero = 0;
  bit [7:0]  m_pend = 0;
  bit [7:0]  m_prot = 0;

  always #4 clk = ~clk;

  sector_lock_seq dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_fresh(acc_fresh), .acc_addr(acc_addr), .acc_data(acc_data),
    .prot_mask(prot_mask), .wr_inhibit(wr_inhibit), .seq_swallow(seq_swallow)
  );

  function automatic bit [16:0] pat(int k);
    bit [16:0] t [6] = '{17'h05555, 17'h1AAAA, 17'h03333, 17'h1CCCC, 17'h100FF, 17'h0FF00};
    return t[k];
  endfunction

  function automatic bit first_ok(bit w, bit f, bit [16:0] a);
    return !w && a == 17'h05555 && (f || m_zero);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One access (or idle cycle when v=0); checks same-cycle outputs and next-cycle mask.
  task automatic access(string tag, bit v, bit w, bit f, bit [16:0] a, bit [7:0] d);
    bit e_sw, e_inh;
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_fresh = f; acc_addr = a; acc_data = d;
    e_sw = 0;
    if (v && w) begin
      if (m_ph == 1 || m_ph == 2) e_sw = 1;
      if (m_ph == 3 && a == 17'h0FF00) e_sw = 1;
    end
    e_inh = v && w && (e_sw || m_prot[a[16:14]]);
    #1;
    chk(tag, "wr_inhibit", int'(wr_inhibit), int'(e_inh));
    chk(tag, "seq_swallow", int'(seq_swallow), int'(e_sw));
    if (v) begin
      case (m_ph)
        0: begin
          if (m_hits != 0 && !w && a == pat(m_hits)) begin
            if (m_hits == 5) begin m_ph = 1; m_hits = 0; end
            else m_hits++;
          end else m_hits = first_ok(w, f, a) ? 1 : 0;
        end
        1: begin
          if (w) begin m_pend = d; m_ph = 2; end
          else begin m_ph = 0; m_hits = first_ok(w, f, a) ? 1 : 0; end
        end
        2: begin
          if (w) begin
            m_hits = 0;
            if (d == ~m_pend) begin m_prot = m_pend; m_ph = 3; end
            else m_ph = 0;
          end else begin m_ph = 0; m_hits = first_ok(w, f, a) ? 1 : 0; end
        end
        default: begin m_ph = 0; m_hits = first_ok(w, f, a) ? 1 : 0; end
      endcase
      m_zero = !w && a == 17'h00000;
    end
    @(posedge clk);
    #1;
    chk(tag, "prot_mask", int'(prot_mask), int'(m_prot));
    acc_valid = 0;
  endtask

  task automatic six_reads(string tag, bit f);
    for (int k = 0; k < 6; k++) access(tag, 1, 0, (k == 0) ? f : 1'b0, pat(k), 8'h00);
  endtask

  task automatic unlock(string tag, bit [7:0] p);
    six_reads(tag, 1);
    access(tag, 1, 1, 0, 17'h1AAAA, p);
    access(tag, 1, 1, 0, 17'h1CCCC, ~p);
    access(tag, 1, 1, 0, 17'h0FF00, 8'h5A);
    access(tag, 1, 0, 0, 17'h00000, 8'h00);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC7));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset default
    chk("R1", "prot_mask", int'(prot_mask), 0);
    rst_n = 1'b1;
    access("R1", 1, 1, 1, 17'h04000, 8'hA5);

    // R3 R4 R8: full unlock with mask 13h
    unlock("R3", 8'h13);
    chk("R3", "mask value", int'(prot_mask), 8'h13);

    // R2: sectors 0,1,4 locked, 2 open, reads never inhibited
    access("R2", 1, 1, 1, 17'h00010, 8'h11);
    access("R2", 1, 1, 1, 17'h07FFF, 8'h11);
    access("R2", 1, 1, 1, 17'h13FFF, 8'h11);
    access("R2", 1, 1, 1, 17'h08000, 8'h11);
    access("R2", 1, 0, 1, 17'h00010, 8'h11);

    // R5: wrong order
    access("R5", 1, 0, 1, 17'h05555, 0);
    access("R5", 1, 0, 0, 17'h03333, 0);
    access("R5", 1, 1, 0, 17'h08000, 8'hFF);
    access("R5", 1, 1, 0, 17'h0C000, 8'h00);

    // R6: seventh read
    six_reads("R6", 1);
    access("R6", 1, 0, 0, 17'h0FF00, 0);
    access("R6", 1, 1, 0, 17'h08000, 8'h00);
    chk("R6", "mask kept", int'(prot_mask), 8'h13);

    // R7: wrong complement, then read in place of complement
    six_reads("R7", 1);
    access("R7", 1, 1, 0, 17'h1AAAA, 8'h55);
    access("R7", 1, 1, 0, 17'h1CCCC, 8'h00);
    access("R7", 1, 1, 0, 17'h08000, 8'h00);
    six_reads("R7", 1);
    access("R7", 1, 1, 0, 17'h1AAAA, 8'h55);
    access("R7", 1, 0, 0, 17'h1CCCC, 8'h00);
    access("R7", 1, 1, 0, 17'h08000, 8'hAA);
    chk("R7", "mask kept", int'(prot_mask), 8'h13);

    // R9: stale select without leading zero read, then with it
    six_reads("R9", 0);
    access("R9", 1, 1, 0, 17'h08000, 8'h00);
    access("R9", 1, 0, 0, 17'h00000, 0);
    six_reads("R9", 0);
    access("R9", 1, 1, 0, 17'h1AAAA, 8'hFF);
    access("R9", 1, 1, 0, 17'h1CCCC, 8'h00);
    chk("R9", "mask value", int'(prot_mask), 8'hFF);

    // R10: restart at step one inside a broken pattern
    access("R10", 1, 0, 1, 17'h05555, 0);
    access("R10", 1, 0, 0, 17'h1AAAA, 0);
    six_reads("R10", 1);
    access("R10", 1, 1, 0, 17'h1AAAA, 8'h80);
    access("R10", 1, 1, 0, 17'h1CCCC, 8'h7F);
    chk("R10", "mask value", int'(prot_mask), 8'h80);

    // R11: idle gaps with misleading addresses between steps
    for (int k = 0; k < 6; k++) begin
      access("R11", 1, 0, (k == 0), pat(k), 0);
      access("R11", 0, 1, 1, 17'h00000, 8'hAA);
    end
    access("R11", 0, 1, 0, 17'h1FFFF, 8'h00);
    access("R11", 1, 1, 0, 17'h1AAAA, 8'h00);
    access("R11", 0, 1, 0, 17'h1FFFF, 8'h00);
    access("R11", 1, 1, 0, 17'h1CCCC, 8'hFF);
    chk("R11", "mask value", int'(prot_mask), 8'h00);

    // R2 R4 R10: random mix biased toward the pattern
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      bit [16:0] a;
      bit [7:0] d = 8'($urandom);
      bit w = ($urandom_range(0, 99) < 30);
      bit v = ($urandom_range(0, 99) < 92);
      if (r < 55) a = pat($urandom_range(0, 5));
      else if (r < 65) a = 17'h00000;
      else if (r < 72) a = 17'h0FF00;
      else a = 17'($urandom);
      if (m_ph == 0 && m_hits != 0 && $urandom_range(0, 99) < 80) begin a = pat(m_hits); w = 0; end
      if (m_ph == 1 && $urandom_range(0, 99) < 70) w = 1;
      if (m_ph == 2 && $urandom_range(0, 99) < 50) begin w = 1; d = ~m_pend; end
      access("R2", v, w, $urandom_range(0, 1), a, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule